// File: doc/BRIEF.md
# Asynchronous Static Memory Cycle Generator

This block converts one read or write request at a time, taken from a simple valid/acknowledge port inside the chip, into a timed cycle on an external asynchronous static-memory bus such as SRAM, PSRAM or NOR flash. It drives the chip select, an address-valid strobe, the output-enable and write-enable strobes, the active-low byte-lane enables and the address. The data bus is brought out as a split output/enable/input triple so the pad ring can build the bidirectional pins. The bus is 8 or 16 bits wide and defaults to 16.

Each phase of the cycle lasts a programmed number of clock cycles: byte-lane lead, address setup, address hold, data strobe, data hold and bus turnaround. Reads and writes each have their own set of phase lengths, except the byte-lane lead, which both share. When multiplexing is enabled, the low address bits are placed on the data bus during the address phases. An external wait line of selectable polarity can stretch the data strobe, but only when asynchronous wait handling is enabled.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and afterwards until a request arrives, mem_cs_n, mem_adv_n, mem_oe_n and mem_we_n are 1, mem_be_n is all ones, mem_dq_oe is 0 and req_ack is 0.
- R2: The byte-lane enables go active exactly cfg_lane_setup cycles before chip select falls, and together with it when that value is 0. For a write, the active lanes are the request's req_be bits (bit i set means lane i is written). A read activates every lane.
- R3: Chip select stays low for address setup + address hold (multiplexed mode only) + data strobe + data hold cycles. The read set of lengths applies to reads and the write set applies to writes. mem_addr holds the request address throughout.
- R4: The strobe, mem_oe_n for a read or mem_we_n for a write, is low for exactly the data setup count when no wait is honoured. An address setup or data setup value of 0 acts as 1.
- R5: With cfg_mux_en=1, mem_adv_n is low for the address setup cycles, and mem_dq_o carries the low address bits with mem_dq_oe=1 during both address setup and address hold. With cfg_mux_en=0, mem_adv_n stays 1 and the address hold phase is skipped.
- R6: For a write, mem_dq_oe is 1 and mem_dq_o carries the write data from the first strobe cycle through the last data hold cycle. Only the lanes enabled by req_be change in the memory.
- R7: Read data is captured in the last strobe cycle and presented on rsp_rdata while req_ack is high. req_ack is high for exactly one cycle, the one right after the strobe ends, for both reads and writes.
- R8: After chip select rises, at least turnaround + 1 cycles pass with chip select and byte lanes inactive before the next access begins. The turnaround count is the one belonging to the finished access.
- R9: mem_wait is active when low, or when high if cfg_wait_pol_high=1. With cfg_async_wait_en=1, an active wait stretches the strobe: the strobe ends in the first cycle that is at or beyond the data setup count and sees wait inactive.
- R10: With cfg_async_wait_en=0, mem_wait has no effect on any strobe length.
- R11: Only one access runs at a time. Each request gets exactly one acknowledge. mem_oe_n and mem_we_n are never low together, and neither is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request pending; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Write lane mask, bit i = lane i |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with req_ack |
| cfg_mux_en | input | 1 | Address/data multiplexing on the data bus |
| cfg_wait_pol_high | input | 1 | Wait active high when 1 |
| cfg_async_wait_en | input | 1 | Honour wait during accesses |
| cfg_lane_setup | input | CNT_W | Byte-lane lead before chip select |
| cfg_rd_asu | input | CNT_W | Read address setup |
| cfg_rd_ahd | input | CNT_W | Read address hold (multiplexed) |
| cfg_rd_dsu | input | CNT_W | Read data setup |
| cfg_rd_dhd | input | CNT_W | Read data hold |
| cfg_rd_turn | input | CNT_W | Turnaround after a read |
| cfg_wr_asu | input | CNT_W | Write address setup |
| cfg_wr_ahd | input | CNT_W | Write address hold (multiplexed) |
| cfg_wr_dsu | input | CNT_W | Write data setup |
| cfg_wr_dhd | input | CNT_W | Write data hold |
| cfg_wr_turn | input | CNT_W | Turnaround after a write |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W | Data bus input value |
| mem_wait | input | 1 | Wait line from the device |

## Verification
The bus outputs are decoded from the phase register, so each phase shows up at the pins in the cycle after the edge that enters it. The bench therefore counts lane-lead, chip-select, strobe, address-valid and drive cycles on falling edges and compares those totals with the programmed lengths when chip select rises. The acknowledge is due in the single cycle after the last strobe cycle, and the bench checks that the strobe was low in the previous sample and high in the current one. Read data is compared in that same sample. Wait is driven for the first K strobe cycles, which makes the expected strobe length max(data setup, K + 1) when wait is honoured and the plain data setup when it is not.

// File: rtl/sram_tc_pkg.sv
package sram_tc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_BLS  = 3'd1,
      PH_ASU  = 3'd2,
      PH_AHD  = 3'd3,
      PH_DSU  = 3'd4,
      PH_DHD  = 3'd5,
      PH_TURN = 3'd6
   } phase_e;

   function automatic logic phase_selects(phase_e p);
      return (p == PH_ASU) || (p == PH_AHD) || (p == PH_DSU) || (p == PH_DHD);
   endfunction

   function automatic logic phase_lanes(phase_e p);
      return (p == PH_BLS) || phase_selects(p);
   endfunction

endpackage

// File: rtl/sram_tc_timing_sel.sv
module sram_tc_timing_sel #(
   parameter int CNT_W = 4
) (
   input  logic             sel_wr,
   input  logic             mux_en,
   input  logic [CNT_W-1:0] lane_setup,
   input  logic [CNT_W-1:0] rd_asu,
   input  logic [CNT_W-1:0] rd_ahd,
   input  logic [CNT_W-1:0] rd_dsu,
   input  logic [CNT_W-1:0] rd_dhd,
   input  logic [CNT_W-1:0] rd_turn,
   input  logic [CNT_W-1:0] wr_asu,
   input  logic [CNT_W-1:0] wr_ahd,
   input  logic [CNT_W-1:0] wr_dsu,
   input  logic [CNT_W-1:0] wr_dhd,
   input  logic [CNT_W-1:0] wr_turn,
   output logic [CNT_W-1:0] len_bls,
   output logic [CNT_W-1:0] len_asu,
   output logic [CNT_W-1:0] len_ahd,
   output logic [CNT_W-1:0] len_dsu,
   output logic [CNT_W-1:0] len_dhd,
   output logic [CNT_W-1:0] len_turn
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] raw_asu, raw_dsu, raw_ahd;

   always_comb begin
      raw_asu  = sel_wr ? wr_asu  : rd_asu;
      raw_ahd  = sel_wr ? wr_ahd  : rd_ahd;
      raw_dsu  = sel_wr ? wr_dsu  : rd_dsu;
      len_dhd  = sel_wr ? wr_dhd  : rd_dhd;
      len_turn = sel_wr ? wr_turn : rd_turn;
      len_bls  = lane_setup;
      // setup phases never shorter than one cycle
      len_asu  = (raw_asu == '0) ? ONE : raw_asu;
      len_dsu  = (raw_dsu == '0) ? ONE : raw_dsu;
      // address hold exists only on a multiplexed bus
      len_ahd  = mux_en ? raw_ahd : '0;
   end

endmodule

// File: rtl/sram_tc_seq.sv
module sram_tc_seq
   import sram_tc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mux_en,
   input  logic             wait_hold,
   input  logic [CNT_W-1:0] len_bls,
   input  logic [CNT_W-1:0] len_asu,
   input  logic [CNT_W-1:0] len_ahd,
   input  logic [CNT_W-1:0] len_dsu,
   input  logic [CNT_W-1:0] len_dhd,
   input  logic [CNT_W-1:0] len_turn,
   output phase_e           phase,
   output logic             data_end
);

   logic [CNT_W-1:0] cnt_q;
   logic             leave;
   phase_e           nxt;
   logic [CNT_W-1:0] nxt_len;

   // phase that follows data hold or data setup, skipping empty ones
   phase_e after_hold;
   always_comb after_hold = (len_turn != '0) ? PH_TURN : PH_IDLE;

   always_comb begin
      data_end = (phase == PH_DSU) && (cnt_q == '0) && !wait_hold;
      leave    = 1'b0;
      nxt      = phase;
      unique case (phase)
         PH_IDLE: begin
            leave = start;
            nxt   = (len_bls != '0) ? PH_BLS : PH_ASU;
         end
         PH_BLS: begin
            leave = (cnt_q == '0);
            nxt   = PH_ASU;
         end
         PH_ASU: begin
            leave = (cnt_q == '0);
            nxt   = (len_ahd != '0) ? PH_AHD : PH_DSU;
         end
         PH_AHD: begin
            leave = (cnt_q == '0);
            nxt   = PH_DSU;
         end
         PH_DSU: begin
            leave = data_end;
            nxt   = (len_dhd != '0) ? PH_DHD : after_hold;
         end
         PH_DHD: begin
            leave = (cnt_q == '0);
            nxt   = after_hold;
         end
         PH_TURN: begin
            leave = (cnt_q == '0);
            nxt   = PH_IDLE;
         end
         default: begin
            leave = 1'b1;
            nxt   = PH_IDLE;
         end
      endcase
   end

   always_comb begin
      unique case (nxt)
         PH_BLS:  nxt_len = len_bls;
         PH_ASU:  nxt_len = len_asu;
         PH_AHD:  nxt_len = len_ahd;
         PH_DSU:  nxt_len = len_dsu;
         PH_DHD:  nxt_len = len_dhd;
         PH_TURN: nxt_len = len_turn;
         default: nxt_len = CNT_W'(1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else if (leave) begin
         phase <= nxt;
         cnt_q <= nxt_len - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R4 / R10: once the count is spent and no wait is honoured, the strobe ends
   assert_dsu_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DSU && cnt_q == '0 && !wait_hold) |=> (phase != PH_DSU));

   assert_ahd_mux_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_AHD) |-> mux_en);

endmodule

// File: rtl/sram_tc_datapath.sv
module sram_tc_datapath
   import sram_tc_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   input  phase_e            phase,
   input  logic              data_end,
   input  logic              mux_en,
   input  logic              wait_pol_high,
   input  logic              async_wait_en,
   input  logic              mem_wait,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              op_wr,
   output logic              wait_hold,
   output logic              req_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_adv_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W/8-1:0] mem_be_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe
);

   localparam int LANES = DATA_W / 8;

   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [LANES-1:0]  lat_lanes;
   logic [DATA_W-1:0] addr_on_dq;
   logic              in_addr_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_wr     <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_lanes <= '0;
      end else if (start) begin
         op_wr     <= req_write;
         lat_addr  <= req_addr;
         lat_wdata <= req_wdata;
         lat_lanes <= req_write ? req_be : {LANES{1'b1}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_ack <= 1'b0;
      else        req_ack <= data_end;
   end

   // per-lane read capture at the last strobe cycle
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rsp_rdata[g*8 +: 8] <= '0;
         else if (data_end && !op_wr)
            rsp_rdata[g*8 +: 8] <= mem_dq_i[g*8 +: 8];
      end
   end

   // wait qualification: polarity then enable
   always_comb wait_hold = async_wait_en && (wait_pol_high ? mem_wait : !mem_wait);

   always_comb begin
      addr_on_dq = DATA_W'(lat_addr);
      in_addr_ph = (phase == PH_ASU) || (phase == PH_AHD);
      mem_cs_n   = !phase_selects(phase);
      mem_adv_n  = !(mux_en && phase == PH_ASU);
      mem_oe_n   = !(phase == PH_DSU && !op_wr);
      mem_we_n   = !(phase == PH_DSU && op_wr);
      mem_be_n   = phase_lanes(phase) ? ~lat_lanes : {LANES{1'b1}};
      mem_addr   = lat_addr;
      mem_dq_oe  = (mux_en && in_addr_ph) ||
                   (op_wr && (phase == PH_DSU || phase == PH_DHD));
      mem_dq_o   = (mux_en && in_addr_ph) ? addr_on_dq : lat_wdata;
   end

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_strobe_in_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   assert_adv_mux_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_adv_n |-> mux_en);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_tc_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                req_ack,
   output logic [DATA_W-1:0]   rsp_rdata,
   input  logic                cfg_mux_en,
   input  logic                cfg_wait_pol_high,
   input  logic                cfg_async_wait_en,
   input  logic [CNT_W-1:0]    cfg_lane_setup,
   input  logic [CNT_W-1:0]    cfg_rd_asu,
   input  logic [CNT_W-1:0]    cfg_rd_ahd,
   input  logic [CNT_W-1:0]    cfg_rd_dsu,
   input  logic [CNT_W-1:0]    cfg_rd_dhd,
   input  logic [CNT_W-1:0]    cfg_rd_turn,
   input  logic [CNT_W-1:0]    cfg_wr_asu,
   input  logic [CNT_W-1:0]    cfg_wr_ahd,
   input  logic [CNT_W-1:0]    cfg_wr_dsu,
   input  logic [CNT_W-1:0]    cfg_wr_dhd,
   input  logic [CNT_W-1:0]    cfg_wr_turn,
   output logic                mem_cs_n,
   output logic                mem_adv_n,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W/8-1:0] mem_be_n,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_dq_o,
   output logic                mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_i,
   input  logic                mem_wait
);

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
      $error("sram_async_ctrl: DATA_W must be 8 or 16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("sram_async_ctrl: CNT_W out of range");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_async_ctrl: ADDR_W must be positive");
   end

   phase_e           phase;
   logic             data_end, start, op_wr, sel_wr, wait_hold;
   logic [CNT_W-1:0] len_bls, len_asu, len_ahd, len_dsu, len_dhd, len_turn;

   // no new access in the acknowledge cycle: the requester has not yet dropped valid
   always_comb start  = (phase == PH_IDLE) && req_valid && !req_ack;
   always_comb sel_wr = (phase == PH_IDLE) ? req_write : op_wr;

   sram_tc_timing_sel #(.CNT_W(CNT_W)) u_sel (
      .sel_wr(sel_wr), .mux_en(cfg_mux_en), .lane_setup(cfg_lane_setup),
      .rd_asu(cfg_rd_asu), .rd_ahd(cfg_rd_ahd), .rd_dsu(cfg_rd_dsu),
      .rd_dhd(cfg_rd_dhd), .rd_turn(cfg_rd_turn),
      .wr_asu(cfg_wr_asu), .wr_ahd(cfg_wr_ahd), .wr_dsu(cfg_wr_dsu),
      .wr_dhd(cfg_wr_dhd), .wr_turn(cfg_wr_turn),
      .len_bls(len_bls), .len_asu(len_asu), .len_ahd(len_ahd),
      .len_dsu(len_dsu), .len_dhd(len_dhd), .len_turn(len_turn)
   );

   sram_tc_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mux_en(cfg_mux_en),
      .wait_hold(wait_hold),
      .len_bls(len_bls), .len_asu(len_asu), .len_ahd(len_ahd),
      .len_dsu(len_dsu), .len_dhd(len_dhd), .len_turn(len_turn),
      .phase(phase), .data_end(data_end)
   );

   sram_tc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .phase(phase), .data_end(data_end), .mux_en(cfg_mux_en),
      .wait_pol_high(cfg_wait_pol_high), .async_wait_en(cfg_async_wait_en),
      .mem_wait(mem_wait), .mem_dq_i(mem_dq_i),
      .op_wr(op_wr), .wait_hold(wait_hold), .req_ack(req_ack),
      .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
   );

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   assert_single_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n) |-> (phase != PH_IDLE));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

   localparam int AW = 20;
   localparam int DW = 16;
   localparam int CW = 4;

   typedef struct {
      bit          wr;
      logic [19:0] addr;
      logic [15:0] exp_rd;
      int          bls, cs, stb, adv, drv, ta;
      string       stag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          req_ack;
   logic [DW-1:0] rsp_rdata;
   logic          c_mux = 0, c_pol = 0, c_aw = 0;
   logic [CW-1:0] c_bls = 0, c_rasu = 1, c_rahd = 0, c_rdsu = 1, c_rdhd = 0, c_rta = 0;
   logic [CW-1:0] c_wasu = 1, c_wahd = 0, c_wdsu = 1, c_wdhd = 0, c_wta = 0;
   logic          mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]    mem_be_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o, mem_dq_i;
   logic          mem_wait = 1'b1;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ack(req_ack), .rsp_rdata(rsp_rdata),
      .cfg_mux_en(c_mux), .cfg_wait_pol_high(c_pol), .cfg_async_wait_en(c_aw),
      .cfg_lane_setup(c_bls),
      .cfg_rd_asu(c_rasu), .cfg_rd_ahd(c_rahd), .cfg_rd_dsu(c_rdsu),
      .cfg_rd_dhd(c_rdhd), .cfg_rd_turn(c_rta),
      .cfg_wr_asu(c_wasu), .cfg_wr_ahd(c_wahd), .cfg_wr_dsu(c_wdsu),
      .cfg_wr_dhd(c_wdhd), .cfg_wr_turn(c_wta),
      .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
      .mem_wait(mem_wait)
   );

   int n_tests = 0, n_fail = 0, issued = 0, acks_total = 0, wait_k = 0;
   item_t q[$];
   logic [15:0] memarr [256];
   logic [15:0] shadow [256];

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // memory model: combinational read, write committed at the end of the strobe
   assign mem_dq_i = !mem_oe_n ? memarr[mem_addr[7:0]] : 16'h0;
   logic        w_pend = 0;
   logic [7:0]  w_a;
   logic [15:0] w_d;
   logic [1:0]  w_b;
   always @(negedge clk) begin
      if (!mem_we_n) begin
         w_pend = 1; w_a = mem_addr[7:0]; w_d = mem_dq_o; w_b = mem_be_n;
      end else if (w_pend) begin
         if (!w_b[0]) memarr[w_a][7:0]  = w_d[7:0];
         if (!w_b[1]) memarr[w_a][15:8] = w_d[15:8];
         w_pend = 0;
      end
   end

   // wait driver: active for the first wait_k strobe cycles
   int wcnt = 0;
   always @(negedge clk) begin
      if (!mem_oe_n || !mem_we_n) begin
         mem_wait <= (wcnt < wait_k) ? c_pol : ~c_pol;
         wcnt++;
      end else begin
         mem_wait <= ~c_pol;
         wcnt = 0;
      end
   end

   // monitor
   bit in_acc = 0, seen_cs = 0, have_prev = 0, prev_stb = 0;
   int m_bls, m_cs, m_stb, m_adv, m_drv, m_advbad, m_acks, gap = 0, last_ta = 0, excl_bad = 0;
   always @(negedge clk) begin
      bit stb, be_act;
      item_t it;
      stb    = !mem_oe_n || !mem_we_n;
      be_act = (mem_be_n != 2'b11);
      if (rst_n) begin
         if ((!mem_oe_n && !mem_we_n) || (stb && mem_cs_n)) excl_bad++;
         if (!in_acc) begin
            if (be_act || !mem_cs_n) begin
               in_acc = 1; seen_cs = 0;
               m_bls = 0; m_cs = 0; m_stb = 0; m_adv = 0; m_drv = 0; m_advbad = 0; m_acks = 0;
               if (have_prev) check(gap >= last_ta + 1, "R8", "idle gap", gap, last_ta + 1);
            end else gap++;
         end
         if (in_acc && q.size() > 0) begin
            if (be_act && mem_cs_n && !seen_cs) m_bls++;
            if (!mem_cs_n) begin seen_cs = 1; m_cs++; end
            if (stb) m_stb++;
            if (!mem_adv_n) begin
               m_adv++;
               if (mem_dq_o != q[0].addr[15:0] || !mem_dq_oe) m_advbad++;
            end
            if (mem_dq_oe) m_drv++;
         end
         if (req_ack) begin
            acks_total++; m_acks++;
            check(prev_stb && !stb, "R7", "ack right after strobe", int'(prev_stb), 1);
            if (q.size() > 0 && !q[0].wr)
               check(rsp_rdata == q[0].exp_rd, "R7", "read data", rsp_rdata, q[0].exp_rd);
         end
         if (in_acc && seen_cs && mem_cs_n && q.size() > 0) begin
            it = q.pop_front();
            check(m_bls == it.bls, "R2", "lane lead", m_bls, it.bls);
            check(m_cs == it.cs, "R3", "select length", m_cs, it.cs);
            check(m_stb == it.stb, it.stag, "strobe length", m_stb, it.stb);
            check(m_adv == it.adv && m_advbad == 0, "R5", "address phase", m_adv, it.adv);
            check(m_drv == it.drv, "R6", "drive length", m_drv, it.drv);
            check(m_acks == 1, "R11", "acks per access", m_acks, 1);
            in_acc = 0; gap = 1; last_ta = it.ta; have_prev = 1;
         end
      end
      prev_stb = stb;
   end

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic access(bit wr, logic [19:0] a, logic [15:0] d, logic [1:0] be, string stag);
      item_t it;
      int asu, ahd, ds, dh;
      asu = eff(wr ? int'(c_wasu) : int'(c_rasu));
      ahd = c_mux ? (wr ? int'(c_wahd) : int'(c_rahd)) : 0;
      ds  = eff(wr ? int'(c_wdsu) : int'(c_rdsu));
      dh  = wr ? int'(c_wdhd) : int'(c_rdhd);
      it.wr = wr; it.addr = a; it.stag = stag;
      it.bls = int'(c_bls);
      it.stb = (c_aw && wait_k > 0 && wait_k + 1 > ds) ? wait_k + 1 : ds;
      it.cs  = asu + ahd + it.stb + dh;
      it.adv = c_mux ? asu : 0;
      it.drv = (c_mux ? asu + ahd : 0) + (wr ? it.stb + dh : 0);
      it.ta  = wr ? int'(c_wta) : int'(c_rta);
      if (wr) begin
         if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
         if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
      end
      it.exp_rd = shadow[a[7:0]];
      q.push_back(it);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      forever begin
         @(negedge clk);
         if (req_ack) break;
      end
      req_valid = 0;
      issued++;
   endtask

   task automatic settle();
      repeat (20) @(negedge clk);
   endtask

   initial begin
      #500000;
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         memarr[i] = 16'hA500 ^ 16'(i * 16'h0101);
         shadow[i] = memarr[i];
      end
      repeat (3) @(negedge clk);
      // R1: reset levels
      check(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 &&
            !mem_dq_oe && !req_ack, "R1", "levels in reset", 0, 1);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe &&
            !req_ack, "R1", "levels after reset", 0, 1);

      // R2 R3 R4 R6 R7 R8: separate read and write sets, no multiplexing
      c_bls = 1; c_rasu = 2; c_rdsu = 3; c_rdhd = 1; c_rta = 2;
      c_wasu = 1; c_wdsu = 2; c_wdhd = 2; c_wta = 1;
      access(1, 20'h00010, 16'h1234, 2'b11, "R4");
      access(1, 20'h00021, 16'hBEEF, 2'b11, "R4");
      access(0, 20'h00010, 16'h0, 2'b00, "R4");
      access(0, 20'h00021, 16'h0, 2'b00, "R4");
      // R6: partial lane write
      access(1, 20'h00010, 16'hCC55, 2'b01, "R4");
      access(0, 20'h00010, 16'h0, 2'b00, "R4");
      access(0, 20'h00033, 16'h0, 2'b00, "R4");
      settle();

      // R5: multiplexed address/data
      c_mux = 1; c_bls = 2; c_rahd = 1; c_wahd = 2; c_wasu = 3;
      access(1, 20'h40042, 16'h7788, 2'b11, "R4");
      access(0, 20'h40042, 16'h0, 2'b00, "R4");
      access(1, 20'h000FE, 16'h9A00, 2'b10, "R4");
      access(0, 20'h000FE, 16'h0, 2'b00, "R4");
      settle();

      // R4: zero counts act as one, empty phases skipped
      c_mux = 0; c_bls = 0; c_rasu = 0; c_rdsu = 0; c_rdhd = 0; c_rta = 0;
      c_wasu = 0; c_wdsu = 0; c_wdhd = 0; c_wta = 0;
      access(1, 20'h00005, 16'h0F0F, 2'b11, "R4");
      access(0, 20'h00005, 16'h0, 2'b00, "R4");
      access(0, 20'h00006, 16'h0, 2'b00, "R4");
      settle();

      // R9: wait active low stretches the strobe
      c_rasu = 1; c_rdsu = 2; c_rdhd = 1; c_rta = 1;
      c_wasu = 1; c_wdsu = 2; c_wdhd = 1; c_wta = 1;
      c_aw = 1; c_pol = 0; settle(); wait_k = 5;
      access(0, 20'h00010, 16'h0, 2'b00, "R9");
      access(1, 20'h00044, 16'h4455, 2'b11, "R9");
      access(0, 20'h00044, 16'h0, 2'b00, "R9");
      wait_k = 0; settle();

      // R9: wait active high
      c_pol = 1; settle(); wait_k = 4;
      access(0, 20'h00021, 16'h0, 2'b00, "R9");
      access(1, 20'h00045, 16'h6677, 2'b11, "R9");
      wait_k = 0; settle();

      // R10: wait ignored when async wait is disabled
      c_aw = 0; c_pol = 0; settle(); wait_k = 6;
      access(0, 20'h00045, 16'h0, 2'b00, "R10");
      access(1, 20'h00046, 16'h1357, 2'b11, "R10");
      access(0, 20'h00046, 16'h0, 2'b00, "R10");
      wait_k = 0; settle();

      // R11: one ack per request, strobes exclusive and inside select
      check(acks_total == issued, "R11", "ack count", acks_total, issued);
      check(excl_bad == 0, "R11", "strobe exclusivity", excl_bad, 0);
      check(q.size() == 0, "R11", "pending accesses", q.size(), 0);
      summary();
      $finish;
   end

endmodule